// File: doc/BRIEF.md
# SPI Flash Command Engine with Shared Ring Buffer

This block is a byte-wide, register-driven SPI master that runs exactly one serial-flash command each time software triggers it. Software programs an opcode register and a packed length register, fills an eight-slot ring buffer through a single data port, and sets a start bit. The engine lowers chip select and sends the opcode. It then shifts the buffered bytes out in SPI mode 0, MSB first, and raises chip select after the last bit.

The same ring buffer carries both directions. Every byte clocked after the opcode leaves the buffer on MOSI, and the byte captured from MISO at the same time replaces it in that slot. The reply bytes therefore sit directly behind the transmit bytes. Nothing ever clears the buffer. The buffer pointer is visible to software, which can read it back and reset it to zero. Reading the same data port walks through the captured bytes.

A known quirk appears when a command has no transmit bytes: the engine then keeps one reply byte fewer than it was asked for. The parameter `FIX_SHORT_READ` selects the variant. With 0 the quirk is reproduced, and with 1 every programmed reply byte is kept.

Top module: `flashcmd_engine`

## Requirements
- R1: After reset, the registers at offsets 0x0, 0x1, 0x2 and 0xD all read 0x00, chip select is high and SCLK is low.
- R2: Offset 0x0 is the opcode register and offset 0x1 the length register: bits 7:4 give the reply count and bits 3:0 the transmit count. Both registers read back exactly what was written. A count field above 8 is treated as 8 on the wire, but the register still reads back the raw value.
- R3: A write or a read at offset 0xC accesses the slot selected by the pointer, then advances the pointer by one modulo 8. The pointer reads back in bits 2:0 of offset 0xD, with bits 7:3 zero.
- R4: Writing offset 0x2 with bit 4 set returns the pointer to 0.
- R5: Writing offset 0x2 with bit 0 set starts a command. Bit 0 of offset 0x2 reads 1 while the command runs and 0 once it is over. Chip select is low only during a command, and SCLK stays low while chip select is high.
- R6: On MOSI the opcode comes first, followed by one byte per transmit and reply count, each taken from the slot at the advancing pointer, sent MSB first. MOSI changes only while SCLK is low.
- R7: Each byte clocked after the opcode is captured from MISO (sampled at the rising SCLK edges) and stored into the slot it was sent from. The pointer ends at its start value plus the transmit and reply counts, modulo 8.
- R8: When the transmit count is 0 and `FIX_SHORT_READ` is 0, the last reply byte is clocked on the wire but neither stored nor counted in the pointer. With `FIX_SHORT_READ` set to 1, all reply bytes are stored.
- R9: The length register keeps its value throughout a command and reads back unchanged afterwards.
- R10: While a command runs, host writes to offsets 0x0, 0x1, 0x2 and 0xC are ignored. Opcode, length, buffer, pointer and the wire sequence are unaffected, and no second command starts.
- R11: Slots the command does not touch keep their earlier contents, because the buffer is never cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access; advances the pointer at offset 0xC |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current offset (combinational) |
| spi_sclk | output | 1 | SPI serial clock, idle low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
If the pointer holds a wrong value, the problem shows first in the next command: MOSI carries the wrong byte within eight SCLK periods of the opcode, and the pointer readback at 0xD differs as soon as the command ends. If the capture path is wrong, the buffer holds bad contents, but these stay invisible until software walks the data port. The bench therefore reads every slot back after each command and compares the whole ring. Faults in the length count or in the quirk handling show up as extra or missing bytes on the wire, and as a pointer that ends off by one.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_LOW,
      ST_HIGH,
      ST_LOAD
   } eng_state_t;

   localparam logic [3:0] OFS_OPCODE = 4'h0;
   localparam logic [3:0] OFS_LENGTH = 4'h1;
   localparam logic [3:0] OFS_CTRL   = 4'h2;
   localparam logic [3:0] OFS_DATA   = 4'hC;
   localparam logic [3:0] OFS_PTR    = 4'hD;

   localparam int CTRL_GO_BIT  = 0;
   localparam int CTRL_CLR_BIT = 4;

endpackage

// File: rtl/flashcmd_ring.sv
module flashcmd_ring #(
   parameter  int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             adv,
   output logic [7:0]       slot,
   output logic [PTR_W-1:0] ptr
);

   logic [7:0] mem [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[g] <= 8'h00;
            else if (wr_en && (ptr == PTR_W'(g)))
               mem[g] <= wr_data;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (clr)
         ptr <= '0;
      else if (adv)
         ptr <= ptr + 1'b1;
   end

   assign slot = mem[ptr];

endmodule

// File: rtl/flashcmd_shifter.sv
module flashcmd_shifter
   import flashcmd_pkg::*;
#(
   parameter int DEPTH          = 8,
   parameter int HALF_DIV       = 2,
   parameter bit FIX_SHORT_READ = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] opcode,
   input  logic [3:0] tx_raw,
   input  logic [3:0] rx_raw,
   input  logic [7:0] slot,
   output logic       store,
   output logic [7:0] store_data,
   output logic       busy,
   output logic       sclk,
   output logic       cs_n,
   output logic       mosi,
   input  logic       miso
);

   localparam int CW = $clog2(2 * HALF_DIV + 1);
   localparam int LW = $clog2(2 * DEPTH + 1);

   function automatic logic [LW-1:0] sat(input logic [3:0] v);
      return (v > 4'(DEPTH)) ? LW'(DEPTH) : LW'(v);
   endfunction

   eng_state_t    state;
   logic [CW-1:0] cnt;
   logic [2:0]    bitn;
   logic [7:0]    sr;
   logic [7:0]    rsr;
   logic [LW-1:0] left;
   logic          is_op;
   logic          tx_zero;
   logic          drop_last;

   generate
      if (FIX_SHORT_READ) begin : g_fixed
         assign drop_last = 1'b0;
      end else begin : g_quirk
         assign drop_last = tx_zero;
      end
   endgenerate

   logic end_phase, end_lead, byte_end;
   assign end_phase = (cnt == CW'(HALF_DIV - 1));
   assign end_lead  = (cnt == CW'(2 * HALF_DIV - 1));
   assign byte_end  = (state == ST_HIGH) && end_phase && (bitn == 3'd7);

   assign store      = byte_end && !is_op && !(drop_last && (left == '0));
   assign store_data = rsr;
   assign sclk       = (state == ST_HIGH);
   assign cs_n       = (state == ST_IDLE);
   assign busy       = (state != ST_IDLE);
   assign mosi       = (state == ST_IDLE) ? 1'b0 : sr[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         bitn    <= 3'd0;
         sr      <= 8'h00;
         rsr     <= 8'h00;
         left    <= '0;
         is_op   <= 1'b0;
         tx_zero <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  sr      <= opcode;
                  is_op   <= 1'b1;
                  left    <= sat(tx_raw) + sat(rx_raw);
                  tx_zero <= (tx_raw == 4'd0);
                  cnt     <= '0;
                  state   <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (end_lead) begin
                  cnt   <= '0;
                  bitn  <= 3'd0;
                  state <= ST_LOW;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_LOW: begin
               if (end_phase) begin
                  rsr   <= {rsr[6:0], miso};
                  cnt   <= '0;
                  state <= ST_HIGH;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_HIGH: begin
               if (end_phase) begin
                  cnt <= '0;
                  if (bitn == 3'd7) begin
                     if (left == '0) begin
                        state <= ST_IDLE;
                     end else begin
                        left  <= left - 1'b1;
                        is_op <= 1'b0;
                        state <= ST_LOAD;
                     end
                  end else begin
                     sr    <= {sr[6:0], 1'b0};
                     bitn  <= bitn + 1'b1;
                     state <= ST_LOW;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_LOAD: begin
               sr    <= slot;
               bitn  <= 3'd0;
               cnt   <= '0;
               state <= ST_LOW;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/flashcmd_engine.sv
module flashcmd_engine
   import flashcmd_pkg::*;
#(
   parameter int DEPTH          = 8,
   parameter int HALF_DIV       = 2,
   parameter bit FIX_SHORT_READ = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [3:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       spi_sclk,
   output logic       spi_cs_n,
   output logic       spi_mosi,
   input  logic       spi_miso
);

   localparam int PTR_W = $clog2(DEPTH);

   initial begin
      if (DEPTH < 2 || DEPTH > 8 || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "flashcmd_engine: DEPTH must be 2, 4 or 8");
      if (HALF_DIV < 1)
         $fatal(1, "flashcmd_engine: HALF_DIV must be at least 1");
   end

   logic [7:0]       opc_q;
   logic [7:0]       cnt_q;
   logic             busy;
   logic             eng_store;
   logic [7:0]       eng_data;
   logic [7:0]       slot;
   logic [PTR_W-1:0] ptr;

   logic host_ok, wr_opc, wr_len, go, clr, data_wr, data_rd;
   assign host_ok = !busy;
   assign wr_opc  = reg_wr && host_ok && (reg_addr == OFS_OPCODE);
   assign wr_len  = reg_wr && host_ok && (reg_addr == OFS_LENGTH);
   assign go      = reg_wr && host_ok && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_GO_BIT];
   assign clr     = reg_wr && host_ok && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_CLR_BIT];
   assign data_wr = reg_wr && host_ok && (reg_addr == OFS_DATA);
   assign data_rd = reg_rd && host_ok && (reg_addr == OFS_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opc_q <= 8'h00;
         cnt_q <= 8'h00;
      end else begin
         if (wr_opc) opc_q <= reg_wdata;
         if (wr_len) cnt_q <= reg_wdata;
      end
   end

   flashcmd_ring #(.DEPTH(DEPTH)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .wr_en   (busy ? eng_store : data_wr),
      .wr_data (busy ? eng_data : reg_wdata),
      .adv     (busy ? eng_store : (data_wr || data_rd)),
      .slot    (slot),
      .ptr     (ptr)
   );

   flashcmd_shifter #(
      .DEPTH          (DEPTH),
      .HALF_DIV       (HALF_DIV),
      .FIX_SHORT_READ (FIX_SHORT_READ)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (go),
      .opcode     (opc_q),
      .tx_raw     (cnt_q[3:0]),
      .rx_raw     (cnt_q[7:4]),
      .slot       (slot),
      .store      (eng_store),
      .store_data (eng_data),
      .busy       (busy),
      .sclk       (spi_sclk),
      .cs_n       (spi_cs_n),
      .mosi       (spi_mosi),
      .miso       (spi_miso)
   );

   always_comb begin
      case (reg_addr)
         OFS_OPCODE: reg_rdata = opc_q;
         OFS_LENGTH: reg_rdata = cnt_q;
         OFS_CTRL:   reg_rdata = {7'b0, busy};
         OFS_DATA:   reg_rdata = slot;
         OFS_PTR:    reg_rdata = 8'(ptr);
         default:    reg_rdata = 8'h00;
      endcase
   end

endmodule

// File: rtl/flashcmd_chk.sv
module flashcmd_chk #(
   parameter  int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_wr,
   input logic             host_rd,
   input logic [3:0]       addr,
   input logic             wd_go,
   input logic             wd_clr,
   input logic             busy,
   input logic [7:0]       cnt_q,
   input logic [PTR_W-1:0] ptr,
   input logic             spi_sclk,
   input logic             spi_cs_n,
   input logic             spi_mosi
);

   // R5: no clock edges outside a chip-select frame
   a_r5_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   // R5: a command begins only from a start write
   a_r5_start_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(host_wr && addr == 4'h2 && wd_go));

   // R6: mode 0, data held while the clock is high
   a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

   // R9: length register frozen during a command
   a_r9_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cnt_q));

   // R4: pointer reset by control bit 4
   a_r4_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !busy && addr == 4'h2 && wd_clr) |=> (ptr == '0));

   // R3: data-port read advances the pointer modulo depth
   a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !busy && addr == 4'hC) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

endmodule

bind flashcmd_engine flashcmd_chk #(.DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .host_wr  (reg_wr),
   .host_rd  (reg_rd),
   .addr     (reg_addr),
   .wd_go    (reg_wdata[0]),
   .wd_clr   (reg_wdata[4]),
   .busy     (busy),
   .cnt_q    (cnt_q),
   .ptr      (ptr),
   .spi_sclk (spi_sclk),
   .spi_cs_n (spi_cs_n),
   .spi_mosi (spi_mosi)
);

// File: tb/flashcmd_engine_tb.sv
`timescale 1ns/1ps
module flashcmd_engine_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [3:0] reg_addr = 4'h0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] rdata_a, rdata_b;
   logic       spi_sclk, spi_cs_n, spi_mosi, spi_miso;
   logic       sclk_b, cs_b, mosi_b;

   always #2 clk = ~clk;

   flashcmd_engine #(.FIX_SHORT_READ(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_a),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso));

   flashcmd_engine #(.FIX_SHORT_READ(1'b1)) u_dut_fix (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_b),
      .spi_sclk(sclk_b), .spi_cs_n(cs_b), .spi_mosi(mosi_b),
      .spi_miso(spi_miso));

   int nchk = 0;
   int nfail = 0;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // reply byte k of a frame (k = 0 is during the opcode)
   function automatic logic [7:0] resp_of(input int k);
      return 8'(k * 37 + 90);
   endfunction

   // bench models of both buffers
   logic [7:0] mem_a [8];
   logic [7:0] mem_b [8];
   int ptr_a = 0;
   int ptr_b = 0;
   logic [7:0] exp_q [$];

   // flash model and wire monitor (scoreboard consumer)
   int wk = 0;
   int wb = 0;
   logic [7:0] wsh = 8'h00;
   logic [7:0] cur_rsp;
   assign cur_rsp  = resp_of(wk);
   assign spi_miso = cur_rsp[7 - wb];

   always @(posedge spi_sclk or posedge spi_cs_n) begin
      if (spi_cs_n) begin
         wk = 0;
         wb = 0;
      end else begin
         wsh = {wsh[6:0], spi_mosi};
         wb++;
         if (wb == 8) begin
            wb = 0;
            wk++;
            if (exp_q.size() == 0) chk("R6 unexpected wire byte", wsh, 8'hxx);
            else chk("R6 wire byte", wsh, exp_q.pop_front());
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] va, output logic [7:0] vb);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1;
      va = rdata_a; vb = rdata_b;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic clr_ptr();
      wr(4'h2, 8'h10);
      ptr_a = 0; ptr_b = 0;
   endtask

   task automatic put(input logic [7:0] d);
      wr(4'hC, d);
      mem_a[ptr_a] = d; ptr_a = (ptr_a + 1) % 8;
      mem_b[ptr_b] = d; ptr_b = (ptr_b + 1) % 8;
   endtask

   task automatic check_ptr(input string req);
      logic [7:0] va, vb;
      rd(4'hD, va, vb);
      chk({req, " pointer"}, va, 8'(ptr_a));
      chk({req, " pointer fixed variant"}, vb, 8'(ptr_b));
   endtask

   task automatic check_ring(input string req);
      logic [7:0] va, vb;
      clr_ptr();
      for (int i = 0; i < 8; i++) begin
         rd(4'hC, va, vb);
         chk({req, " slot"}, va, mem_a[i]);
         chk({req, " slot fixed variant"}, vb, mem_b[i]);
      end
      ptr_a = 0; ptr_b = 0;
   endtask

   // driver: program, predict wire bytes and buffer effect, start
   task automatic start_cmd(input logic [7:0] op, input logic [7:0] len);
      int txs, rxs, tot;
      wr(4'h0, op);
      wr(4'h1, len);
      txs = (len[3:0] > 8) ? 8 : int'(len[3:0]);
      rxs = (len[7:4] > 8) ? 8 : int'(len[7:4]);
      tot = txs + rxs;
      exp_q.push_back(op);
      for (int i = 0; i < tot; i++) begin
         exp_q.push_back(mem_a[ptr_a]);
         if (!(txs == 0 && i == tot - 1)) begin
            mem_a[ptr_a] = resp_of(i + 1);
            ptr_a = (ptr_a + 1) % 8;
         end
         mem_b[ptr_b] = resp_of(i + 1);
         ptr_b = (ptr_b + 1) % 8;
      end
      wr(4'h2, 8'h01);
   endtask

   task automatic finish_cmd(input string req);
      logic [7:0] va, vb;
      int n = 0;
      rd(4'h2, va, vb);
      chk("R5 busy after start", va, 8'h01);
      while (va[0] && n < 5000) begin
         rd(4'h2, va, vb);
         n++;
      end
      chk("R5 busy cleared", va, 8'h00);
      chk("R5 busy cleared fixed variant", vb, 8'h00);
      chk("R5 chip select released", {7'b0, spi_cs_n}, 8'h01);
      chk({req, " R6 all wire bytes seen"}, 8'(exp_q.size()), 8'h00);
      exp_q.delete();
   endtask

   initial begin
      #(4 * 150000);
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      logic [7:0] va, vb;
      for (int i = 0; i < 8; i++) begin mem_a[i] = 8'h00; mem_b[i] = 8'h00; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'h0, va, vb); chk("R1 opcode reset", va, 8'h00);
      rd(4'h1, va, vb); chk("R1 length reset", va, 8'h00);
      rd(4'h2, va, vb); chk("R1 control reset", va, 8'h00);
      rd(4'hD, va, vb); chk("R1 pointer reset", va, 8'h00);
      chk("R1 cs idle", {7'b0, spi_cs_n}, 8'h01);
      chk("R1 sclk idle", {7'b0, spi_sclk}, 8'h00);

      // R3 data port fill with wrap and readback
      clr_ptr();
      for (int i = 0; i < 8; i++) put(8'h10 + 8'(i));
      check_ptr("R3 wrap");
      check_ring("R3 readback");

      // R6 R7 R11 three transmit, two reply
      clr_ptr();
      put(8'hAA); put(8'hBB); put(8'hCC);
      clr_ptr();
      check_ptr("R4 cleared");
      start_cmd(8'h03, 8'h23);
      finish_cmd("R6 tx3 rx2");
      rd(4'h0, va, vb); chk("R2 opcode readback", va, 8'h03);
      rd(4'h1, va, vb); chk("R9 length readback", va, 8'h23);
      check_ptr("R7 end pointer");
      check_ring("R7 R11 buffer");

      // R10 writes during a command are ignored
      clr_ptr();
      put(8'h44);
      clr_ptr();
      start_cmd(8'h0B, 8'h11);
      wr(4'h0, 8'hEE);
      wr(4'h1, 8'h77);
      wr(4'hC, 8'h99);
      wr(4'h2, 8'h11);
      finish_cmd("R10 interfered");
      rd(4'h0, va, vb); chk("R10 opcode kept", va, 8'h0B);
      rd(4'h1, va, vb); chk("R10 length kept", va, 8'h11);
      check_ptr("R10 pointer");
      repeat (30) @(negedge clk);
      chk("R10 no second command", {7'b0, spi_cs_n}, 8'h01);
      check_ring("R10 buffer");

      // R8 no transmit bytes, three replies
      clr_ptr();
      start_cmd(8'h9F, 8'h30);
      finish_cmd("R8 tx0 rx3");
      check_ptr("R8 short read");
      check_ring("R8 buffer");

      // R8 one reply only
      clr_ptr();
      start_cmd(8'h05, 8'h10);
      finish_cmd("R8 tx0 rx1");
      check_ptr("R8 single reply");

      // R2 saturation of both count fields
      clr_ptr();
      start_cmd(8'h5A, 8'h9A);
      finish_cmd("R2 saturated");
      rd(4'h1, va, vb); chk("R2 R9 raw length readback", va, 8'h9A);
      check_ptr("R2 R7 saturated pointer");
      check_ring("R2 R11 buffer");

      // opcode only
      start_cmd(8'h06, 8'h00);
      finish_cmd("R6 opcode only");
      check_ptr("R7 opcode only");

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule